// File: doc/BRIEF.md
# BCD calendar time counter

This block keeps wall-clock time for a system: seconds, minutes, hours, a weekday, the day of the month, the month and a three-digit year. A prescaler counts enables of a slow reference clock. Each time it completes a full one-second period, the calendar moves forward by one second. The rollover chain goes through minutes, hours, days and months. Month lengths and Gregorian leap years are handled.

Software reaches every field through a small register bus. Each field reads back in BCD, with the tens digit above the units digit. A BCD write sets a field, but only while the global enable is high. The current fields are also brought out in BCD, together with a one-cycle strobe at each second boundary. An alarm comparator outside the block uses these outputs.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, weekday and year all read 0 (the year meaning 1900). Day of month reads 0x01, month reads 0x01, and `sec_pulse` is low.
- R2: While `enable` is high, one second passes after every TICKS_PER_SEC cycles in which `ref_tick` is high. At that point `sec_pulse` is high for exactly one cycle, and in that same cycle the outputs show the advanced time.
- R3: While `enable` is low, the time holds and no strobe is given. When `enable` rises, the prescaler starts again from a full period, so the next second needs TICKS_PER_SEC fresh reference ticks.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0.
- R5: An hour wrap advances the weekday modulo 7 (6 goes to 0) and advances the day of month.
- R6: Months hold 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30 and 31 days. When the day passes the month length it goes to 1 and the month advances. December then wraps to January and increments the year.
- R7: February has 29 days when y = year + 1900 is divisible by 4 and not by 100, or is divisible by 400. So 2000 and 2024 are leap years, and 1900, 2023 and 2100 are not.
- R8: A stored month index outside 0..11 counts as a 31-day month. Advancing from such an index, or from index 11, gives month index 0 and increments the year.
- R9: Field addresses on `bus_addr` are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month and 6 year. Address 7 reads 0. A byte field reads as the tens digit in bits [7:4] and the units digit in bits [3:0]. A write decodes tens*10+units from `bus_wdata[7:0]`.
- R10: The month is kept zero-based internally. A read returns the BCD of the stored index + 1 (modulo 256), and a write stores the decoded value − 1. A written 0x00 therefore reads back as 0x00 and counts as out of range.
- R11: The year reads as BCD(year mod 100) in bits [7:0] and the hundreds digit in bits [11:8]. A write sets the year to decode(bits[7:0]) + 100*bits[11:8].
- R12: A write to any field while `enable` is low changes nothing.
- R13: If a write and a second boundary fall in the same cycle, the written field takes the written value and every other field takes its advanced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global run enable; also gates writes |
| ref_tick | input | 1 | One-cycle enable from the reference clock |
| bus_wr | input | 1 | Write strobe for the addressed field |
| bus_addr | input | ADDR_W | Field select |
| bus_wdata | input | 12 | BCD write data |
| bus_rdata | output | 12 | BCD read data for the addressed field |
| sec_pulse | output | 1 | One-cycle strobe at each second boundary |
| bcd_sec | output | 8 | Current seconds, BCD |
| bcd_min | output | 8 | Current minutes, BCD |
| bcd_hour | output | 8 | Current hours, BCD |
| bcd_wday | output | 8 | Current weekday, BCD |
| bcd_mday | output | 8 | Current day of month, BCD |
| bcd_mon | output | 8 | Current month, one-based BCD |
| bcd_year | output | 12 | Current three-digit BCD year |

## Verification
The calendar is started just before many different boundaries. One start is the last second of a year, on the last weekday, which runs the whole carry chain at once. Others are February 28 in the years 1900, 2000, 2023, 2024 and 2100, which separate a correct 4/100/400 leap test from one that only checks divisibility by 4. The end of a 30-day month and the end of a 31-day month show whether the month-length table is used.

Month writes of 0x00 and 0x13 check the off-by-one storage and the 31-day fallback. A year written with invalid BCD digits shows that the write decodes the value before storing it. Enable is toggled part way through a second, which tells a restarted prescaler apart from one that only pauses. A write placed exactly on a second boundary shows which source wins for each field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int DATA_W = 12;

   localparam logic [2:0] FLD_SEC  = 3'd0;
   localparam logic [2:0] FLD_MIN  = 3'd1;
   localparam logic [2:0] FLD_HOUR = 3'd2;
   localparam logic [2:0] FLD_WDAY = 3'd3;
   localparam logic [2:0] FLD_MDAY = 3'd4;
   localparam logic [2:0] FLD_MON  = 3'd5;
   localparam logic [2:0] FLD_YEAR = 3'd6;

   // Calendar held in binary; month is zero-based, year counts from the base.
   typedef struct packed {
      logic [10:0] year;
      logic [7:0]  mon;
      logic [7:0]  mday;
      logic [7:0]  wday;
      logic [7:0]  hour;
      logic [7:0]  min;
      logic [7:0]  sec;
   } cal_t;

   localparam cal_t CAL_RESET = '{year: 11'd0, mon: 8'd0, mday: 8'd1,
                                  wday: 8'd0, hour: 8'd0, min: 8'd0, sec: 8'd0};

   function automatic logic [7:0] bin2bcd8(input logic [7:0] x);
      logic [7:0] t;
      logic [7:0] u;
      t = x / 8'd10;
      u = x % 8'd10;
      return {t[3:0], u[3:0]};
   endfunction

   function automatic logic [7:0] bcd2bin8(input logic [7:0] v);
      return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
   endfunction

   function automatic logic [11:0] year2bcd(input logic [10:0] y);
      logic [10:0] lo;
      logic [10:0] hi;
      lo = y % 11'd100;
      hi = (y % 11'd1000) / 11'd100;
      return {hi[3:0], bin2bcd8(lo[7:0])};
   endfunction

   function automatic logic [10:0] bcd2year(input logic [11:0] v);
      return {3'd0, bcd2bin8(v[7:0])} + ({7'd0, v[11:8]} * 11'd100);
   endfunction

   function automatic logic is_leap(input logic [15:0] y);
      return (((y % 16'd4) == 16'd0) && ((y % 16'd100) != 16'd0))
             || ((y % 16'd400) == 16'd0);
   endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
module rtc_sec_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ref_tick,
   output logic boundary
);
   localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam bit IS_POW2 = ((1 << CW) == TICKS_PER_SEC);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          terminal;

   generate
      if (IS_POW2) begin : g_pow2
         // Natural wrap of the counter marks the period.
         assign terminal = &cnt_q;
         assign cnt_nxt  = cnt_q + 1'b1;
      end else begin : g_cmp
         assign terminal = (cnt_q == CW'(TICKS_PER_SEC - 1));
         assign cnt_nxt  = terminal ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   // Cleared while disabled, so a rising enable starts a full period.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!enable) begin
         cnt_q <= '0;
      end else if (ref_tick) begin
         cnt_q <= cnt_nxt;
      end
   end

   assign boundary = enable & ref_tick & terminal;

endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
   import rtc_cal_pkg::*;
#(
   parameter int YEAR_BASE = 1900
) (
   input  cal_t cur,
   output cal_t nxt
);
   logic [8:0]  s1;
   logic [8:0]  m1;
   logic [8:0]  h1;
   logic [8:0]  w1;
   logic [8:0]  d1;
   logic [8:0]  mo1;
   logic [4:0]  dim;
   logic [15:0] yfull;

   always_comb begin
      yfull = 16'(cur.year) + 16'(YEAR_BASE);
      case (cur.mon)
         8'd1:                    dim = is_leap(yfull) ? 5'd29 : 5'd28;
         8'd3, 8'd5, 8'd8, 8'd10: dim = 5'd30;
         default:                 dim = 5'd31;
      endcase
   end

   always_comb begin
      s1  = {1'b0, cur.sec}  + 9'd1;
      m1  = {1'b0, cur.min}  + 9'd1;
      h1  = {1'b0, cur.hour} + 9'd1;
      w1  = {1'b0, cur.wday} + 9'd1;
      d1  = {1'b0, cur.mday} + 9'd1;
      mo1 = {1'b0, cur.mon}  + 9'd1;
      nxt = cur;
      if (s1 < 9'd60) begin
         nxt.sec = s1[7:0];
      end else begin
         nxt.sec = 8'd0;
         if (m1 < 9'd60) begin
            nxt.min = m1[7:0];
         end else begin
            nxt.min = 8'd0;
            if (h1 < 9'd24) begin
               nxt.hour = h1[7:0];
            end else begin
               nxt.hour = 8'd0;
               nxt.wday = (w1 >= 9'd7) ? 8'd0 : w1[7:0];
               if (d1 <= {4'd0, dim}) begin
                  nxt.mday = d1[7:0];
               end else begin
                  nxt.mday = 8'd1;
                  if (mo1 < 9'd12) begin
                     nxt.mon = mo1[7:0];
                  end else begin
                     nxt.mon  = 8'd0;
                     nxt.year = cur.year + 11'd1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/rtc_bcd_view.sv
module rtc_bcd_view
   import rtc_cal_pkg::*;
(
   input  cal_t        cal,
   output logic [7:0]  bcd_sec,
   output logic [7:0]  bcd_min,
   output logic [7:0]  bcd_hour,
   output logic [7:0]  bcd_wday,
   output logic [7:0]  bcd_mday,
   output logic [7:0]  bcd_mon,
   output logic [11:0] bcd_year
);
   assign bcd_sec  = bin2bcd8(cal.sec);
   assign bcd_min  = bin2bcd8(cal.min);
   assign bcd_hour = bin2bcd8(cal.hour);
   assign bcd_wday = bin2bcd8(cal.wday);
   assign bcd_mday = bin2bcd8(cal.mday);
   assign bcd_mon  = bin2bcd8(cal.mon + 8'd1);
   assign bcd_year = year2bcd(cal.year);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_cal_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int YEAR_BASE     = 1900,
   parameter int ADDR_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ref_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [11:0]       bus_wdata,
   output logic [11:0]       bus_rdata,
   output logic              sec_pulse,
   output logic [7:0]        bcd_sec,
   output logic [7:0]        bcd_min,
   output logic [7:0]        bcd_hour,
   output logic [7:0]        bcd_wday,
   output logic [7:0]        bcd_mday,
   output logic [7:0]        bcd_mon,
   output logic [11:0]       bcd_year
);
   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_ticks
         $error("rtc_calendar: TICKS_PER_SEC must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("rtc_calendar: ADDR_W must be at least 3");
      end
   endgenerate

   cal_t       cal_q;
   cal_t       cal_adv;
   cal_t       cal_d;
   logic       boundary;
   logic       in_window;
   logic [2:0] fld;

   assign fld = bus_addr[2:0];

   generate
      if (ADDR_W > 3) begin : g_wide
         assign in_window = ~|bus_addr[ADDR_W-1:3];
      end else begin : g_narrow
         assign in_window = 1'b1;
      end
   endgenerate

   rtc_sec_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .ref_tick (ref_tick),
      .boundary (boundary)
   );

   rtc_cal_advance #(.YEAR_BASE(YEAR_BASE)) u_adv (
      .cur (cal_q),
      .nxt (cal_adv)
   );

   // Advanced time first, then the addressed field is overridden by a write.
   always_comb begin
      cal_d = boundary ? cal_adv : cal_q;
      if (bus_wr && enable && in_window) begin
         case (fld)
            FLD_SEC:  cal_d.sec  = bcd2bin8(bus_wdata[7:0]);
            FLD_MIN:  cal_d.min  = bcd2bin8(bus_wdata[7:0]);
            FLD_HOUR: cal_d.hour = bcd2bin8(bus_wdata[7:0]);
            FLD_WDAY: cal_d.wday = bcd2bin8(bus_wdata[7:0]);
            FLD_MDAY: cal_d.mday = bcd2bin8(bus_wdata[7:0]);
            FLD_MON:  cal_d.mon  = bcd2bin8(bus_wdata[7:0]) - 8'd1;
            FLD_YEAR: cal_d.year = bcd2year(bus_wdata);
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cal_q     <= CAL_RESET;
         sec_pulse <= 1'b0;
      end else begin
         cal_q     <= cal_d;
         sec_pulse <= boundary;
      end
   end

   rtc_bcd_view u_view (
      .cal      (cal_q),
      .bcd_sec  (bcd_sec),
      .bcd_min  (bcd_min),
      .bcd_hour (bcd_hour),
      .bcd_wday (bcd_wday),
      .bcd_mday (bcd_mday),
      .bcd_mon  (bcd_mon),
      .bcd_year (bcd_year)
   );

   always_comb begin
      bus_rdata = '0;
      if (in_window) begin
         case (fld)
            FLD_SEC:  bus_rdata = {4'd0, bcd_sec};
            FLD_MIN:  bus_rdata = {4'd0, bcd_min};
            FLD_HOUR: bus_rdata = {4'd0, bcd_hour};
            FLD_WDAY: bus_rdata = {4'd0, bcd_wday};
            FLD_MDAY: bus_rdata = {4'd0, bcd_mday};
            FLD_MON:  bus_rdata = {4'd0, bcd_mon};
            FLD_YEAR: bus_rdata = bcd_year;
            default:  bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        bus_wr,
   input logic        sec_pulse,
   input logic [7:0]  bcd_sec,
   input logic [7:0]  bcd_min,
   input logic [7:0]  bcd_hour,
   input logic [7:0]  bcd_wday,
   input logic [7:0]  bcd_mday,
   input logic [7:0]  bcd_mon,
   input logic [11:0] bcd_year
);
   // R2: the strobe never lasts two cycles
   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |=> !sec_pulse);

   // R2: a strobe only follows an enabled cycle
   a_r2_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sec_pulse |-> $past(enable));

   // R3: time frozen and no strobe while disabled
   a_r3_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> ($stable(bcd_sec) && $stable(bcd_min) && $stable(bcd_hour)
                   && $stable(bcd_wday) && $stable(bcd_mday) && $stable(bcd_mon)
                   && $stable(bcd_year) && !sec_pulse));

   // R12: a write while disabled leaves every field alone
   a_r12_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !enable) |=> ($stable(bcd_sec) && $stable(bcd_min) && $stable(bcd_hour)
                               && $stable(bcd_mday) && $stable(bcd_mon) && $stable(bcd_year)));

   // R4: second 59 wraps to 0 on a strobe without a write
   a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && $past(bcd_sec) == 8'h59 && !$past(bus_wr))
         |-> (bcd_sec == 8'h00 && bcd_min != $past(bcd_min)));

   // R5: end of day clears hours and minutes
   a_r5_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && $past(bcd_sec) == 8'h59 && $past(bcd_min) == 8'h59
       && $past(bcd_hour) == 8'h23 && !$past(bus_wr))
         |-> (bcd_hour == 8'h00 && bcd_min == 8'h00));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .bus_wr    (bus_wr),
   .sec_pulse (sec_pulse),
   .bcd_sec   (bcd_sec),
   .bcd_min   (bcd_min),
   .bcd_hour  (bcd_hour),
   .bcd_wday  (bcd_wday),
   .bcd_mday  (bcd_mday),
   .bcd_mon   (bcd_mon),
   .bcd_year  (bcd_year)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
   localparam int T = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        ref_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [11:0] bus_wdata = 12'd0;
   logic [11:0] bus_rdata;
   logic        sec_pulse;
   logic [7:0]  bcd_sec, bcd_min, bcd_hour, bcd_wday, bcd_mday, bcd_mon;
   logic [11:0] bcd_year;

   int    checks = 0;
   int    errors = 0;
   string phase = "R1";
   bit    cmp_on = 1'b0;

   always #2 clk = ~clk;

   rtc_calendar #(.TICKS_PER_SEC(T), .YEAR_BASE(1900), .ADDR_W(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ref_tick(ref_tick),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sec_pulse(sec_pulse),
      .bcd_sec(bcd_sec), .bcd_min(bcd_min), .bcd_hour(bcd_hour),
      .bcd_wday(bcd_wday), .bcd_mday(bcd_mday), .bcd_mon(bcd_mon),
      .bcd_year(bcd_year)
   );

   // ---------------- reference model ----------------
   int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, m_pc;
   bit m_pulse;

   function automatic int f_bcd(input int x);
      return (((x / 10) % 16) * 16) + (x % 10);
   endfunction
   function automatic int f_dec(input int v);
      return ((v / 16) % 16) * 10 + (v % 16);
   endfunction
   function automatic int f_ybcd(input int y);
      return f_bcd(y % 100) + ((y % 1000) / 100) * 256;
   endfunction
   function automatic int f_dim(input int mon, input int yr);
      int y;
      y = yr + 1900;
      if (mon >= 12) return 31;
      if (mon == 1) return ((y % 4 == 0 && y % 100 != 0) || y % 400 == 0) ? 29 : 28;
      if (mon == 3 || mon == 5 || mon == 8 || mon == 10) return 30;
      return 31;
   endfunction
   function automatic int f_exp_rd(input int a);
      case (a)
         0: return f_bcd(m_sec);
         1: return f_bcd(m_min);
         2: return f_bcd(m_hour);
         3: return f_bcd(m_wday);
         4: return f_bcd(m_mday);
         5: return f_bcd((m_mon + 1) % 256);
         6: return f_ybcd(m_year);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      bit bnd;
      int d;
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_hour = 0; m_wday = 0;
         m_mday = 1; m_mon = 0; m_year = 0; m_pc = 0; m_pulse = 0;
      end else begin
         bnd = 0;
         if (!enable) m_pc = 0;
         else if (ref_tick) begin
            if (m_pc == T - 1) begin m_pc = 0; bnd = 1; end
            else m_pc = m_pc + 1;
         end
         if (bnd) begin
            m_sec = m_sec + 1;
            if (m_sec >= 60) begin
               m_sec = 0; m_min = m_min + 1;
               if (m_min >= 60) begin
                  m_min = 0; m_hour = m_hour + 1;
                  if (m_hour >= 24) begin
                     m_hour = 0;
                     m_wday = m_wday + 1;
                     if (m_wday >= 7) m_wday = 0;
                     d = f_dim(m_mon, m_year);
                     m_mday = m_mday + 1;
                     if (m_mday > d) begin
                        m_mday = 1; m_mon = m_mon + 1;
                        if (m_mon >= 12) begin m_mon = 0; m_year = (m_year + 1) % 2048; end
                     end
                  end
               end
            end
         end
         if (bus_wr && enable) begin
            case (int'(bus_addr))
               0: m_sec  = f_dec(int'(bus_wdata[7:0]));
               1: m_min  = f_dec(int'(bus_wdata[7:0]));
               2: m_hour = f_dec(int'(bus_wdata[7:0]));
               3: m_wday = f_dec(int'(bus_wdata[7:0]));
               4: m_mday = f_dec(int'(bus_wdata[7:0]));
               5: m_mon  = (f_dec(int'(bus_wdata[7:0])) + 255) % 256;
               6: m_year = f_dec(int'(bus_wdata[7:0])) + int'(bus_wdata[11:8]) * 100;
               default: ;
            endcase
         end
         m_pulse = bnd;
      end
   end

   // Compare every cycle, away from the active edge.
   always @(posedge clk) begin
      #1;
      if (cmp_on) begin
         checks++;
         if (int'(bcd_sec) != f_bcd(m_sec) || int'(bcd_min) != f_bcd(m_min)
             || int'(bcd_hour) != f_bcd(m_hour) || int'(bcd_wday) != f_bcd(m_wday)
             || int'(bcd_mday) != f_bcd(m_mday) || int'(bcd_mon) != f_bcd((m_mon + 1) % 256)
             || int'(bcd_year) != f_ybcd(m_year) || sec_pulse != m_pulse
             || int'(bus_rdata) != f_exp_rd(int'(bus_addr))) begin
            errors++;
            $display("FAIL %s model: actual %h:%h:%h wd%h %h/%h/%h p%0b rd%h expected %h:%h:%h wd%h %h/%h/%h p%0b rd%h",
                     phase, bcd_hour, bcd_min, bcd_sec, bcd_wday, bcd_mday, bcd_mon, bcd_year,
                     sec_pulse, bus_rdata, f_bcd(m_hour), f_bcd(m_min), f_bcd(m_sec),
                     f_bcd(m_wday), f_bcd(m_mday), f_bcd((m_mon + 1) % 256), f_ybcd(m_year),
                     m_pulse, f_exp_rd(int'(bus_addr)));
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 3'(a); bus_wdata = 12'(d); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 3'(a);
      @(posedge clk);
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic to_pulse(output int k);
      k = 0;
      do begin
         @(posedge clk);
         #1;
         k++;
      end while (!sec_pulse && k < 50);
   endtask

   task automatic run_secs(input int n);
      int c;
      c = 0;
      @(negedge clk);
      ref_tick = 1'b1;
      while (c < n) begin
         @(posedge clk);
         #1;
         if (sec_pulse) c++;
      end
      @(negedge clk);
      ref_tick = 1'b0;
   endtask

   task automatic set_time(input int h, input int mi, input int s, input int wd,
                           input int d, input int mo, input int y);
      wr(6, y); wr(5, mo); wr(4, d); wr(3, wd); wr(2, h); wr(1, mi); wr(0, s);
   endtask

   task automatic leap_case(input int y, input int exp_day, input int exp_mon);
      set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02, y);
      run_secs(1);
      chk("R7", $sformatf("day after Feb 28 year %h", y), int'(bcd_mday), exp_day);
      chk("R7", $sformatf("month after Feb 28 year %h", y), int'(bcd_mon), exp_mon);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired in phase %s: actual running expected finished", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin : main
      int v;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset values
      phase = "R1";
      rd(0, v); chk("R1", "reset seconds", v, 'h00);
      rd(2, v); chk("R1", "reset hours", v, 'h00);
      rd(4, v); chk("R1", "reset day", v, 'h01);
      rd(5, v); chk("R1", "reset month", v, 'h01);
      rd(6, v); chk("R1", "reset year", v, 'h000);
      chk("R1", "reset strobe", int'(sec_pulse), 0);

      // R12 writes ignored while disabled; R3 time holds while disabled
      phase = "R12";
      wr(0, 'h30);
      wr(6, 'h555);
      rd(0, v); chk("R12", "seconds after disabled write", v, 'h00);
      rd(6, v); chk("R12", "year after disabled write", v, 'h000);
      phase = "R3";
      @(negedge clk); ref_tick = 1'b1;
      repeat (10) @(posedge clk);
      #1 chk("R3", "seconds while disabled", int'(bcd_sec), 'h00);

      // R2 one second per T reference ticks
      phase = "R2";
      @(negedge clk); enable = 1'b1;
      to_pulse(k);
      chk("R2", "ticks to first strobe", k, T);
      chk("R2", "seconds at strobe", int'(bcd_sec), 'h01);
      @(posedge clk);
      #1 chk("R2", "strobe width", int'(sec_pulse), 0);
      to_pulse(k);
      chk("R2", "ticks to second strobe", k, T - 1);

      // R3 prescaler restarts on rising enable
      phase = "R3";
      repeat (2) @(posedge clk);
      @(negedge clk); enable = 1'b0;
      @(negedge clk); enable = 1'b1;
      to_pulse(k);
      chk("R3", "ticks after re-enable", k, T);
      chk("R3", "seconds after re-enable", int'(bcd_sec), 'h03);
      @(negedge clk); ref_tick = 1'b0;

      // R4 R5 R6 full carry chain at new year
      phase = "R4";
      set_time('h23, 'h59, 'h58, 'h06, 'h31, 'h12, 'h099);
      run_secs(1);
      chk("R4", "seconds step", int'(bcd_sec), 'h59);
      run_secs(1);
      chk("R4", "seconds wrap", int'(bcd_sec), 'h00);
      chk("R4", "minutes wrap", int'(bcd_min), 'h00);
      chk("R4", "hours wrap", int'(bcd_hour), 'h00);
      chk("R5", "weekday 6 to 0", int'(bcd_wday), 'h00);
      chk("R6", "day wrap", int'(bcd_mday), 'h01);
      chk("R6", "December to January", int'(bcd_mon), 'h01);
      chk("R6", "year increment", int'(bcd_year), 'h100);

      // R5 plain day advance
      phase = "R5";
      set_time('h23, 'h59, 'h59, 'h03, 'h14, 'h06, 'h124);
      run_secs(1);
      chk("R5", "weekday advance", int'(bcd_wday), 'h04);
      chk("R5", "day advance", int'(bcd_mday), 'h15);

      // R6 month lengths
      phase = "R6";
      set_time('h23, 'h59, 'h59, 'h01, 'h30, 'h04, 'h124);
      run_secs(1);
      chk("R6", "April 30 day", int'(bcd_mday), 'h01);
      chk("R6", "April 30 month", int'(bcd_mon), 'h05);
      set_time('h23, 'h59, 'h59, 'h01, 'h30, 'h01, 'h124);
      run_secs(1);
      chk("R6", "January 30 day", int'(bcd_mday), 'h31);

      // R7 leap rule
      phase = "R7";
      leap_case('h100, 'h29, 'h02);
      leap_case('h000, 'h01, 'h03);
      leap_case('h124, 'h29, 'h02);
      leap_case('h123, 'h01, 'h03);
      leap_case('h200, 'h01, 'h03);

      // R10 R8 month offset and out-of-range index
      phase = "R10";
      wr(5, 'h00);
      rd(5, v); chk("R10", "month written 0x00", v, 'h00);
      phase = "R8";
      set_time('h23, 'h59, 'h59, 'h01, 'h30, 'h00, 'h050);
      run_secs(1);
      chk("R8", "out-of-range month has day 31", int'(bcd_mday), 'h31);
      wr(2, 'h23); wr(1, 'h59); wr(0, 'h59);
      run_secs(1);
      chk("R8", "day wrap from bad month", int'(bcd_mday), 'h01);
      chk("R8", "month from bad index", int'(bcd_mon), 'h01);
      chk("R8", "year from bad month", int'(bcd_year), 'h051);
      set_time('h23, 'h59, 'h59, 'h01, 'h31, 'h13, 'h050);
      rd(5, v); chk("R10", "month written 0x13", v, 'h13);
      run_secs(1);
      chk("R8", "index 12 wraps to January", int'(bcd_mon), 'h01);

      // R11 year format and R9 encoding
      phase = "R11";
      wr(6, 'h987);
      rd(6, v); chk("R11", "year 987", v, 'h987);
      wr(6, 'h0AB);
      rd(6, v); chk("R11", "year decoded from 0x0AB", v, 'h111);
      phase = "R9";
      wr(0, 'h47);
      rd(0, v); chk("R9", "seconds readback", v, 'h47);
      chk("R9", "seconds port", int'(bcd_sec), 'h47);
      wr(4, 'h1F);
      rd(4, v); chk("R9", "day decoded from 0x1F", v, 'h25);
      rd(7, v); chk("R9", "unmapped address", v, 'h000);

      // R13 write on a second boundary
      phase = "R13";
      wr(2, 'h07); wr(1, 'h10); wr(0, 'h59);
      @(negedge clk); enable = 1'b0;
      @(negedge clk); enable = 1'b1; ref_tick = 1'b1;
      repeat (T - 1) @(posedge clk);
      @(negedge clk);
      bus_addr = 3'd1; bus_wdata = 12'h042; bus_wr = 1'b1;
      @(posedge clk);
      #1;
      chk("R13", "strobe on write cycle", int'(sec_pulse), 1);
      chk("R13", "seconds advanced", int'(bcd_sec), 'h00);
      chk("R13", "minutes take written value", int'(bcd_min), 'h42);
      chk("R13", "hours unchanged", int'(bcd_hour), 'h07);
      @(negedge clk); bus_wr = 1'b0; ref_tick = 1'b0;

      // R12 again after running
      phase = "R12";
      @(negedge clk); enable = 1'b0;
      wr(2, 'h05);
      rd(2, v); chk("R12", "hours after disabled write", v, 'h07);

      @(negedge clk);
      cmp_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule